// File: doc/BRIEF.md
# Level and Edge GPIO Interrupt Bank

This block is a bank of 32 general-purpose pins behind a simple 32-bit register port. Each pin has its own output-enable bit and data-out bit. Every input is synchronised through a two-flop chain, and the synchronised value can be read back as data in. Each pin can watch its synchronised input for four conditions: low level, high level, rising edge and falling edge. Each condition has its own enable register, and any mix of the four may be enabled on a pin at the same time.

A detected condition sets that pin's bit in a sticky status register. Software clears a status bit by writing 1 to it. The bank drives two outputs. The interrupt line is the OR of status masked by the interrupt enable register. The wake line is the OR of status masked by the wake enable register. Level conditions behave differently from edges: while an enabled level holds, its status bit cannot be cleared. An edge sets its bit once per transition.

Data out, interrupt enable and wake enable each have a pair of alias addresses, one that sets bits and one that clears them. Software can therefore change single pins without a read-modify-write.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset:
  - status, interrupt enable, wake enable, data out and all four detect registers read 0.
  - the output-enable register (0x34) reads all ones.
  - `irq_out` and `wake_out` are low.
- R2: A 1 in bit i of the output-enable register (0x34) makes pin i an input (`pad_oe[i]`=0); a 0 makes it an output (`pad_oe[i]`=1). `pad_out` always equals the data-out register.
- R3: A read of 0x38 returns the pad inputs after two flops. A pad change driven between clock edges shows in `rdata` after the second following rising edge and not after the first.
- R4: Writing to status at 0x18 clears exactly the bits written as 1; bits written 0 keep their value. If a detect event for a bit occurs in the same cycle as its clear, the bit stays set.
- R5: With low-level detect (0x40) or high-level detect (0x44) enabled, the pin's status bit is set while that level holds. It stays set across a write-1-to-clear for as long as the level remains.
- R6: Rising detect (0x48) sets status on a 0-to-1 change of the synchronised input, and falling detect (0x4C) on a 1-to-0 change. Once cleared, the bit stays clear until the next such transition.
- R7: The four detect enables of a pin act independently and are ORed. All 16 combinations give the union of their individual effects.
- R8: The set aliases (0x64 interrupt enable, 0x84 wake enable, 0x94 data out) OR the written 1s into their register. The clear aliases (0x60, 0x80, 0x90) remove the written 1s. Bits written 0 are untouched. A read of either alias returns the register.
- R9: `irq_out` is high exactly when some bit is set in both status and interrupt enable. `wake_out` is high exactly when some bit is set in both status and wake enable.
- R10: A direct write to 0x1C, 0x34, 0x3C or 0x40..0x4C replaces the whole register, and the new value reads back. An unmapped address reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | NPINS | Raw pad inputs |
| pad_out | output | NPINS | Data-out register value |
| pad_oe | output | NPINS | Output drive enable, 1 = drive |
| irq_out | output | 1 | Bank interrupt |
| wake_out | output | 1 | Bank wake request |

## Verification
A wrong synchroniser depth shows at the ports as data in arriving one edge early or late. The bench samples on each side of the second edge, so this is caught. A corrupted detect term or status bit shows on the next status read. It also shows at once on `irq_out` and `wake_out`, because the bench enables the pin under test in both masks. A clear that wrongly beats a level event shows on the read directly after the clear write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [7:0] A_STAT     = 8'h18;
  localparam logic [7:0] A_IEN      = 8'h1C;
  localparam logic [7:0] A_DIR      = 8'h34;
  localparam logic [7:0] A_DIN      = 8'h38;
  localparam logic [7:0] A_DOUT     = 8'h3C;
  localparam logic [7:0] A_DET_LO   = 8'h40;
  localparam logic [7:0] A_DET_HI   = 8'h44;
  localparam logic [7:0] A_DET_RISE = 8'h48;
  localparam logic [7:0] A_DET_FALL = 8'h4C;
  localparam logic [7:0] A_IEN_CLR  = 8'h60;
  localparam logic [7:0] A_IEN_SET  = 8'h64;
  localparam logic [7:0] A_WK_CLR   = 8'h80;
  localparam logic [7:0] A_WK_SET   = 8'h84;
  localparam logic [7:0] A_DOUT_CLR = 8'h90;
  localparam logic [7:0] A_DOUT_SET = 8'h94;

  typedef struct packed {
    logic lo;
    logic hi;
    logic rise;
    logic fall;
  } trig_cfg_t;

  // level condition present on the synchronised sample
  function automatic logic level_hit(trig_cfg_t c, logic cur);
    return (c.lo & ~cur) | (c.hi & cur);
  endfunction

  // transition between previous and current synchronised samples
  function automatic logic edge_hit(trig_cfg_t c, logic cur, logic prev);
    return (c.rise & cur & ~prev) | (c.fall & ~cur & prev);
  endfunction

  // sticky status: an event wins over a clear in the same cycle
  function automatic logic next_stat(logic q, logic clr, logic hit);
    return (q & ~clr) | hit;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[LAST];
    end
  end

  assign cur  = chain[LAST];
  assign prev = prev_q;
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [7:0]   addr,
  input  logic [W-1:0] wd,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dout_q,
  output logic [W-1:0] ien_q,
  output logic [W-1:0] wken_q,
  output logic [W-1:0] det_lo_q,
  output logic [W-1:0] det_hi_q,
  output logic [W-1:0] det_rise_q,
  output logic [W-1:0] det_fall_q
);
  function automatic logic [W-1:0] upd(logic [W-1:0] q, logic [W-1:0] m, logic set_bits);
    return set_bits ? (q | m) : (q & ~m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q      <= '1;
      dout_q     <= '0;
      ien_q      <= '0;
      wken_q     <= '0;
      det_lo_q   <= '0;
      det_hi_q   <= '0;
      det_rise_q <= '0;
      det_fall_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:      dir_q      <= wd;
        A_DOUT:     dout_q     <= wd;
        A_DOUT_SET: dout_q     <= upd(dout_q, wd, 1'b1);
        A_DOUT_CLR: dout_q     <= upd(dout_q, wd, 1'b0);
        A_IEN:      ien_q      <= wd;
        A_IEN_SET:  ien_q      <= upd(ien_q, wd, 1'b1);
        A_IEN_CLR:  ien_q      <= upd(ien_q, wd, 1'b0);
        A_WK_SET:   wken_q     <= upd(wken_q, wd, 1'b1);
        A_WK_CLR:   wken_q     <= upd(wken_q, wd, 1'b0);
        A_DET_LO:   det_lo_q   <= wd;
        A_DET_HI:   det_hi_q   <= wd;
        A_DET_RISE: det_rise_q <= wd;
        A_DET_FALL: det_fall_q <= wd;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] det_lo,
  input  logic [W-1:0] det_hi,
  input  logic [W-1:0] det_rise,
  input  logic [W-1:0] det_fall,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status,
  output logic [W-1:0] hit,
  output logic [W-1:0] lvl_hit
);
  logic [W-1:0] nxt;

  for (genvar g = 0; g < W; g++) begin : g_pin
    trig_cfg_t cfg;
    assign cfg        = '{lo: det_lo[g], hi: det_hi[g], rise: det_rise[g], fall: det_fall[g]};
    assign lvl_hit[g] = level_hit(cfg, cur[g]);
    assign hit[g]     = lvl_hit[g] | edge_hit(cfg, cur[g], prev[g]);
    assign nxt[g]     = next_stat(status[g], clr[g], hit[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= nxt;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq_out,
  output logic             wake_out
);
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] dir_q, dout_q, ien_q, wken_q;
  logic [NPINS-1:0] det_lo_q, det_hi_q, det_rise_q, det_fall_q;
  logic [NPINS-1:0] s_cur, s_prev;
  logic [NPINS-1:0] status_q, hit_vec, lvl_hit_vec, stat_clr;
  logic [31:0]      unused_hi;

  assign wd        = wdata[NPINS-1:0];
  assign unused_hi = wdata;
  assign stat_clr  = (wr_en && addr == A_STAT) ? wd : '0;

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .cur(s_cur), .prev(s_prev)
  );

  gpio_ctl_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wd(wd),
    .dir_q(dir_q), .dout_q(dout_q), .ien_q(ien_q), .wken_q(wken_q),
    .det_lo_q(det_lo_q), .det_hi_q(det_hi_q),
    .det_rise_q(det_rise_q), .det_fall_q(det_fall_q)
  );

  gpio_evt_status #(.W(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .cur(s_cur), .prev(s_prev),
    .det_lo(det_lo_q), .det_hi(det_hi_q), .det_rise(det_rise_q), .det_fall(det_fall_q),
    .clr(stat_clr), .status(status_q), .hit(hit_vec), .lvl_hit(lvl_hit_vec)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:                 rdata[NPINS-1:0] = status_q;
      A_IEN, A_IEN_SET,
      A_IEN_CLR:              rdata[NPINS-1:0] = ien_q;
      A_WK_SET, A_WK_CLR:     rdata[NPINS-1:0] = wken_q;
      A_DIR:                  rdata[NPINS-1:0] = dir_q;
      A_DIN:                  rdata[NPINS-1:0] = s_cur;
      A_DOUT, A_DOUT_SET,
      A_DOUT_CLR:             rdata[NPINS-1:0] = dout_q;
      A_DET_LO:               rdata[NPINS-1:0] = det_lo_q;
      A_DET_HI:               rdata[NPINS-1:0] = det_hi_q;
      A_DET_RISE:             rdata[NPINS-1:0] = det_rise_q;
      A_DET_FALL:             rdata[NPINS-1:0] = det_fall_q;
      default:                rdata = '0;
    endcase
  end

  assign pad_out  = dout_q;
  assign pad_oe   = ~dir_q;
  assign irq_out  = |(status_q & ien_q);
  assign wake_out = |(status_q & wken_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       addr,
  input logic [NPINS-1:0] wd,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] ien,
  input logic [NPINS-1:0] wken,
  input logic [NPINS-1:0] hit,
  input logic [NPINS-1:0] lvl_hit,
  input logic             irq_out,
  input logic             wake_out
);
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT) |=> ((status & $past(wd) & ~$past(hit)) == '0));

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(hit)) == $past(hit)));

  a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_hit != '0) |=> ((status & $past(lvl_hit)) == $past(lvl_hit)));

  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(hit)) == '0));

  a_r8_ien_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IEN_SET) |=> ((ien & $past(wd)) == $past(wd)));

  a_r8_wake_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_WK_CLR) |=> ((wken & $past(wd)) == '0));

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq_out);

  a_r9_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wken == '0) |-> !wake_out);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wd(wd),
  .status(status_q), .ien(ien_q), .wken(wken_q), .hit(hit_vec),
  .lvl_hit(lvl_hit_vec), .irq_out(irq_out), .wake_out(wake_out)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic          irq_out, wake_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_out(irq_out), .wake_out(wake_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset values
    rd(8'h18, v); chk("R1 status", v, 32'h0);
    rd(8'h1C, v); chk("R1 irq enable", v, 32'h0);
    rd(8'h84, v); chk("R1 wake enable", v, 32'h0);
    rd(8'h34, v); chk("R1 output enable", v, 32'hFFFF_FFFF);
    rd(8'h3C, v); chk("R1 data out", v, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(8'h40 + 8'(4*k), v); chk("R1 detect reg", v, 32'h0);
    end
    chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
    chk("R1 wake_out", {31'h0, wake_out}, 32'h0);

    // R2 direction and pad drive; R10 direct writes
    wr(8'h34, 32'h0000_FFFF);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(8'h34, v); chk("R10 dir readback", v, 32'h0000_FFFF);
    wr(8'h3C, 32'hDEAD_BEEF);
    chk("R2 pad_out", pad_out, 32'hDEAD_BEEF);

    // R8 aliases
    wr(8'h3C, 32'h0);
    wr(8'h94, 32'h0F0F_0F0F);
    wr(8'h90, 32'h0303_0000);
    rd(8'h3C, v); chk("R8 dout set/clr", v, 32'h0C0C_0F0F);
    rd(8'h90, v); chk("R8 dout clr alias read", v, 32'h0C0C_0F0F);
    rd(8'h94, v); chk("R8 dout set alias read", v, 32'h0C0C_0F0F);
    wr(8'h64, 32'h0000_0030);
    wr(8'h60, 32'h0000_0010);
    rd(8'h1C, v); chk("R8 ien set/clr", v, 32'h0000_0020);
    wr(8'h84, 32'h8000_0081);
    wr(8'h80, 32'h0000_0001);
    rd(8'h80, v); chk("R8 wake set/clr", v, 32'h8000_0080);

    // R10 unmapped
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, v); chk("R10 unmapped read", v, 32'h0);
    rd(8'h3C, v); chk("R10 unmapped write ignored", v, 32'h0C0C_0F0F);

    wr(8'h1C, 32'h0);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFF);

    // R3 two-flop data in latency
    addr = 8'h38;
    @(negedge clk);
    pad_in = 32'h1234_5678;
    @(negedge clk); #1; chk("R3 din after one edge", rdata, 32'h0);
    @(negedge clk); #1; chk("R3 din after two edges", rdata, 32'h1234_5678);
    pad_in = '0;
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);

    // R4 write-1-to-clear
    wr(8'h48, 32'h0000_000F);
    pad_in = 32'h0000_000F;
    idle(4);
    rd(8'h18, v); chk("R4 edges captured", v, 32'h0000_000F);
    wr(8'h18, 32'h0000_0005);
    rd(8'h18, v); chk("R4 partial clear", v, 32'h0000_000A);
    wr(8'h18, 32'h0);
    rd(8'h18, v); chk("R4 zero write no effect", v, 32'h0000_000A);
    chk("R9 irq masked", {31'h0, irq_out}, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, v); chk("R6 edge stays clear", v, 32'h0);
    wr(8'h44, 32'h0000_0100);
    pad_in = 32'h0000_010F;
    idle(4);
    wr(8'h18, 32'h0000_0100);
    rd(8'h18, v); chk("R4 event beats clear", v, 32'h0000_0100);
    wr(8'h44, 32'h0);
    wr(8'h48, 32'h0);
    pad_in = '0;
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);

    // R5 R6 R7 R9 exhaustive trigger combinations
    for (int c = 0; c < 16; c++) begin
      int p;
      logic [31:0] m, e;
      bit lo, hi, ri, fa;
      p  = (c * 5 + 3) % 32;
      m  = 32'h1 << p;
      lo = c[0]; hi = c[1]; ri = c[2]; fa = c[3];
      wr(8'h40, lo ? m : 32'h0);
      wr(8'h44, hi ? m : 32'h0);
      wr(8'h48, ri ? m : 32'h0);
      wr(8'h4C, fa ? m : 32'h0);
      wr(8'h1C, m);
      wr(8'h80, 32'hFFFF_FFFF);
      wr(8'h84, m);
      pad_in = '0;
      idle(4);
      wr(8'h18, 32'hFFFF_FFFF);
      e = lo ? m : 32'h0;
      rd(8'h18, v); chk("R5 low level after clear", v, e);
      chk("R9 irq low phase", {31'h0, irq_out}, {31'h0, e != 0});
      pad_in = m;
      idle(4);
      e = (lo | hi | ri) ? m : 32'h0;
      rd(8'h18, v); chk("R7 after rise", v, e);
      chk("R9 wake after rise", {31'h0, wake_out}, {31'h0, e != 0});
      wr(8'h18, 32'hFFFF_FFFF);
      e = hi ? m : 32'h0;
      rd(8'h18, v); chk("R5 high level after clear", v, e);
      chk("R9 irq high phase", {31'h0, irq_out}, {31'h0, e != 0});
      pad_in = '0;
      idle(4);
      e = (lo | hi | fa) ? m : 32'h0;
      rd(8'h18, v); chk("R6 after fall", v, e);
      chk("R9 irq after fall", {31'h0, irq_out}, {31'h0, e != 0});
      wr(8'h18, 32'hFFFF_FFFF);
      e = lo ? m : 32'h0;
      rd(8'h18, v); chk("R7 final clear", v, e);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule